// File: doc/BRIEF.md
# USB Root Hub Port Status and Control Register

This block holds the status and control word for one downstream port of a USB host controller root hub. Hardware around the port reports events as single-cycle pulses: a connect or disconnect, a change in the over-current indicator, the port being disabled by a fault, and the end of a selective resume. Each pulse is captured in a sticky change flag. The flag stays set until software writes a 1 to its bit position. The block also shows the attached device speed and the port power state.

Software reaches the word over a plain 32-bit register bus. A write pulse carries data, and the read data always shows the current word, one combinational step from state. Bit positions 8 and 9 are commands on write but status on read. Writing a 1 at position 8 turns port power on, and writing a 1 at position 9 turns it off. On read, those same positions report the power state and the device speed. The port power state is held inside the block and driven out to the port power switch.

Two static configuration inputs shape the behaviour. A device-removable strap selects the reset value of the connect change flag. A no-power-switching input makes power read as on at all times.

Top module: `portStatusReg`

## Requirements
- R1: During reset, change flags 19, 18 and 17 clear to 0, change flag 16 takes the value of `cfgRemovable`, and the internal port power state clears to off.
- R2: A one-cycle pulse on `evtConnect`, `evtDisable`, `evtResume` or `evtOverCurrent` sets read bit 16, 17, 18 or 19 respectively, visible on the cycle after the clock edge that samples the pulse.
- R3: A bus write with a 1 at any of bit positions 16 to 19 clears that change flag. A 0 at those positions leaves the flag unchanged.
- R4: If an event pulse and a write of 1 reach the same change flag on the same clock edge, the flag stays set.
- R5: Read bits 31:20, 15:10, 7:5 and 4:0 are always 0, and writes to those positions have no effect on any state.
- R6: A write with bit 8 = 1 and bit 9 = 0 turns port power on. A write with bit 9 = 1 turns it off, including when bit 8 is also 1.
- R7: Read bit 8 and output `portPowerOn` equal the port power state ORed with `cfgNoPowerSwitch`.
- R8: Read bit 9 equals `devLowSpeed` while `devConnected` is 1, and reads 0 while `devConnected` is 0.
- R9: With no write and no event pulse, the change flags and the port power state hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock |
| rstN | input | 1 | Synchronous reset, active low |
| cfgRemovable | input | 1 | Device-removable strap; selects the reset value of flag 16 |
| cfgNoPowerSwitch | input | 1 | Port power is not switched; power reads as on |
| busWrEn | input | 1 | One-cycle write strobe for this register |
| busWrData | input | 32 | Write data |
| busRdData | output | 32 | Current register word |
| evtConnect | input | 1 | Connect or disconnect detected (pulse) |
| evtDisable | input | 1 | Port disabled by a hardware event (pulse) |
| evtResume | input | 1 | Selective resume sequence completed (pulse) |
| evtOverCurrent | input | 1 | Over-current indicator changed (pulse) |
| devConnected | input | 1 | A device is currently attached |
| devLowSpeed | input | 1 | The attached device is low speed |
| portPowerOn | output | 1 | Port power switch control |

## Verification
Directed cases run first. Reset is applied with the removable strap high and then low, which separates a strap-dependent reset value from a constant one. An event and a clear are aimed at the same flag on one edge, which shows whether the event or the clear wins. A write carries both power commands at once, which shows which command has priority. Writes containing only 0s at the flag positions and 1s at the reserved positions show that neither disturbs any state. A seeded random phase then mixes event pulses, whole-word writes and changing speed and connection inputs, which exercises how set, clear and hold interact across all four flags together.

// File: rtl/portStatusPkg.sv
package portStatusPkg;
  localparam int DATA_W      = 32;
  localparam int CHG_N       = 4;
  localparam int CHG_LSB     = 16;
  localparam int PWR_SET_BIT = 8;
  localparam int PWR_CLR_BIT = 9;

  // change flag index, in bit order above CHG_LSB
  localparam int EV_CONN = 0;
  localparam int EV_DIS  = 1;
  localparam int EV_RES  = 2;
  localparam int EV_OC   = 3;

  typedef struct packed {
    logic [CHG_N-1:0] clrChg;
    logic             setPwr;
    logic             clrPwr;
  } strobeT;
endpackage

// File: rtl/portStatusCtrl.sv
module portStatusCtrl
  import portStatusPkg::*;
(
  input  logic              busWrEn,
  input  logic [DATA_W-1:0] busWrData,
  output strobeT            strobe
);
  // positions that carry no command are consumed here on purpose
  logic unusedWr;
  assign unusedWr = ^{busWrData[DATA_W-1:CHG_LSB+CHG_N],
                      busWrData[CHG_LSB-1:PWR_CLR_BIT+1],
                      busWrData[PWR_SET_BIT-1:0]};

  always_comb begin
    strobe        = '0;
    if (busWrEn) begin
      strobe.clrChg = busWrData[CHG_LSB +: CHG_N];
      // clear-power dominates a simultaneous set-power
      strobe.clrPwr = busWrData[PWR_CLR_BIT];
      strobe.setPwr = busWrData[PWR_SET_BIT] & ~busWrData[PWR_CLR_BIT];
    end
  end
endmodule

// File: rtl/portStatusPath.sv
module portStatusPath
  import portStatusPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgRemovable,
  input  logic              cfgNoPowerSwitch,
  input  strobeT            strobe,
  input  logic [CHG_N-1:0]  evt,
  input  logic              devConnected,
  input  logic              devLowSpeed,
  output logic [DATA_W-1:0] rdData,
  output logic              pwrOn
);
  logic [CHG_N-1:0] chgQ;
  logic             pwrQ;

  for (genvar i = 0; i < CHG_N; i++) begin : g_chg
    logic rstVal;
    assign rstVal = (i == EV_CONN) ? cfgRemovable : 1'b0;

    // reset value may come from the strap, so reset is synchronous
    always_ff @(posedge clk) begin
      if (!rstN)                 chgQ[i] <= rstVal;
      else if (evt[i])           chgQ[i] <= 1'b1;
      else if (strobe.clrChg[i]) chgQ[i] <= 1'b0;
    end

    a_r2_event_sets: assert property (@(posedge clk) disable iff (!rstN)
      evt[i] |=> rdData[CHG_LSB+i]);
    a_r3_clear_flag: assert property (@(posedge clk) disable iff (!rstN)
      (strobe.clrChg[i] && !evt[i]) |=> !rdData[CHG_LSB+i]);
    a_r9_flag_holds: assert property (@(posedge clk) disable iff (!rstN)
      (!strobe.clrChg[i] && !evt[i]) |=> $stable(rdData[CHG_LSB+i]));
  end

  always_ff @(posedge clk) begin
    if (!rstN)              pwrQ <= 1'b0;
    else if (strobe.clrPwr) pwrQ <= 1'b0;
    else if (strobe.setPwr) pwrQ <= 1'b1;
  end

  always_comb begin
    rdData                   = '0;
    rdData[CHG_LSB +: CHG_N] = chgQ;
    rdData[PWR_SET_BIT]      = pwrQ | cfgNoPowerSwitch;
    rdData[PWR_CLR_BIT]      = devConnected & devLowSpeed;
  end

  assign pwrOn = pwrQ | cfgNoPowerSwitch;

  a_r6_power_off: assert property (@(posedge clk) disable iff (!rstN)
    strobe.clrPwr |=> !pwrQ);
  a_r6_power_on: assert property (@(posedge clk) disable iff (!rstN)
    strobe.setPwr |=> pwrQ);
  a_r9_power_holds: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.setPwr && !strobe.clrPwr) |=> $stable(pwrQ));
  a_r7_power_read: assert property (@(posedge clk) disable iff (!rstN)
    cfgNoPowerSwitch |-> (rdData[PWR_SET_BIT] && pwrOn));
endmodule

// File: rtl/portStatusReg.sv
module portStatusReg
  import portStatusPkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        cfgRemovable,
  input  logic        cfgNoPowerSwitch,
  input  logic        busWrEn,
  input  logic [31:0] busWrData,
  output logic [31:0] busRdData,
  input  logic        evtConnect,
  input  logic        evtDisable,
  input  logic        evtResume,
  input  logic        evtOverCurrent,
  input  logic        devConnected,
  input  logic        devLowSpeed,
  output logic        portPowerOn
);
  strobeT           strobe;
  logic [CHG_N-1:0] evt;

  always_comb begin
    evt          = '0;
    evt[EV_CONN] = evtConnect;
    evt[EV_DIS]  = evtDisable;
    evt[EV_RES]  = evtResume;
    evt[EV_OC]   = evtOverCurrent;
  end

  portStatusCtrl u_ctrl (
    .busWrEn   (busWrEn),
    .busWrData (busWrData),
    .strobe    (strobe)
  );

  portStatusPath u_path (
    .clk              (clk),
    .rstN             (rstN),
    .cfgRemovable     (cfgRemovable),
    .cfgNoPowerSwitch (cfgNoPowerSwitch),
    .strobe           (strobe),
    .evt              (evt),
    .devConnected     (devConnected),
    .devLowSpeed      (devLowSpeed),
    .rdData           (busRdData),
    .pwrOn            (portPowerOn)
  );

  a_r5_reserved_zero: assert property (@(posedge clk) disable iff (!rstN)
    (busRdData[31:20] == '0) && (busRdData[15:10] == '0) && (busRdData[7:0] == '0));
endmodule

// File: tb/portStatusReg_bench.sv
module portStatusReg_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cfgRemovable = 1'b0;
  logic        cfgNoPowerSwitch = 1'b0;
  logic        busWrEn = 1'b0;
  logic [31:0] busWrData = '0;
  logic [31:0] busRdData;
  logic        evtConnect = 1'b0, evtDisable = 1'b0, evtResume = 1'b0, evtOverCurrent = 1'b0;
  logic        devConnected = 1'b0, devLowSpeed = 1'b0;
  logic        portPowerOn;

  int checks = 0;
  int errors = 0;
  logic [3:0] expChg;
  logic       expPwr;

  always #(CLK_PERIOD/2) clk = ~clk;

  portStatusReg u_portStatusReg (.*);

  function automatic logic [31:0] expRead(logic [3:0] chg, logic pwr, logic nps,
                                          logic conn, logic ls);
    logic [31:0] r = '0;
    r[19:16] = chg;
    r[8]     = pwr | nps;
    r[9]     = conn & ls;
    return r;
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic checkAll(string req);
    check(req, busRdData, expRead(expChg, expPwr, cfgNoPowerSwitch, devConnected, devLowSpeed));
    check(req, {31'b0, portPowerOn}, {31'b0, expPwr | cfgNoPowerSwitch});
  endtask

  // drive at negedge, model the edge, return at the next negedge
  task automatic cyc(logic we, logic [31:0] d, logic [3:0] ev);
    busWrEn = we; busWrData = d;
    evtConnect = ev[0]; evtDisable = ev[1]; evtResume = ev[2]; evtOverCurrent = ev[3];
    @(posedge clk);
    for (int i = 0; i < 4; i++) begin
      if (ev[i])              expChg[i] = 1'b1;
      else if (we && d[16+i]) expChg[i] = 1'b0;
    end
    if (we && d[9])      expPwr = 1'b0;
    else if (we && d[8]) expPwr = 1'b1;
    @(negedge clk);
    busWrEn = 1'b0; busWrData = '0;
    evtConnect = 1'b0; evtDisable = 1'b0; evtResume = 1'b0; evtOverCurrent = 1'b0;
  endtask

  task automatic doReset(logic rem);
    cfgRemovable = rem;
    rstN = 1'b0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    expChg = {3'b000, rem};
    expPwr = 1'b0;
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    @(negedge clk);

    // R1 reset with strap high and low
    doReset(1'b1);
    check("R1 strap high", busRdData, 32'h0001_0000);
    check("R1 power off", {31'b0, portPowerOn}, 32'd0);
    doReset(1'b0);
    check("R1 strap low", busRdData, 32'h0000_0000);

    // R2 each event sets its own flag
    for (int i = 0; i < 4; i++) begin
      cyc(1'b0, '0, 4'b0001 << i);
      check("R2 event sets flag", busRdData[19:16], 4'b0001 << i);
      cyc(1'b1, 32'h1 << (16 + i), 4'b0000);
      check("R3 clear flag", busRdData[19:16], 4'b0000);
    end

    // R3 zero write does not clear
    cyc(1'b0, '0, 4'b1111);
    cyc(1'b1, 32'h0000_0000, 4'b0000);
    check("R3 zero write keeps", busRdData[19:16], 4'b1111);
    cyc(1'b1, 32'h0005_0000, 4'b0000);
    check("R3 partial clear", busRdData[19:16], 4'b1010);

    // R4 event beats clear
    cyc(1'b1, 32'h000F_0000, 4'b0010);
    check("R4 event wins", busRdData[19:16], 4'b0010);

    // R5 reserved writes ignored
    cyc(1'b1, 32'hFFF0_FCFF, 4'b0000);
    check("R5 reserved write", busRdData, 32'h0002_0000);

    // R6 power commands
    cyc(1'b1, 32'h0000_0100, 4'b0000);
    check("R6 set power", {31'b0, portPowerOn}, 32'd1);
    cyc(1'b1, 32'h0000_0300, 4'b0000);
    check("R6 clear wins", {31'b0, portPowerOn}, 32'd0);
    check("R6 read bit8", {31'b0, busRdData[8]}, 32'd0);

    // R7 no power switching forces on
    cfgNoPowerSwitch = 1'b1;
    #1;
    check("R7 forced read", {31'b0, busRdData[8]}, 32'd1);
    check("R7 forced output", {31'b0, portPowerOn}, 32'd1);
    cfgNoPowerSwitch = 1'b0;

    // R8 speed gated by connect
    devLowSpeed = 1'b1; devConnected = 1'b0; #1;
    check("R8 not connected", {31'b0, busRdData[9]}, 32'd0);
    devConnected = 1'b1; #1;
    check("R8 low speed", {31'b0, busRdData[9]}, 32'd1);
    devLowSpeed = 1'b0; #1;
    check("R8 full speed", {31'b0, busRdData[9]}, 32'd0);

    // R9 idle cycles hold
    cyc(1'b1, 32'h0000_0100, 4'b1101);
    repeat (3) cyc(1'b0, 32'hFFFF_FFFF, 4'b0000);
    checkAll("R9 hold");

    // random mix, all requirements against the model
    for (int n = 0; n < 600; n++) begin
      logic we;
      logic [31:0] d;
      logic [3:0] ev;
      we = ($urandom % 4) == 0;
      d  = $urandom;
      if ($urandom % 2) d[19:16] = d[19:16] & $urandom;
      ev = $urandom & $urandom & $urandom;
      devConnected     = $urandom;
      devLowSpeed      = $urandom;
      cfgNoPowerSwitch = ($urandom % 8) == 0;
      cyc(we, d, ev);
      checkAll("R2/R3/R4/R6/R7/R8/R9 random");
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule